// File: doc/BRIEF.md
# Host Mailbox Byte-FIFO Register Block

This block lets a host processor exchange bytes with a system-management microcontroller. Two byte queues sit between them. The outbound queue runs from host to controller, and the inbound queue runs from controller to host. The host sees eight 32-bit words addressed by word index. Index 0 holds the interrupt requests and masks, index 1 is the data port, and index 2 holds the status flags. Indices 3 to 7 are reserved.

A host write to the data port queues the byte found in bits 15:8 of the written word. A host read of the data port removes the oldest inbound byte and returns it in bits 15:8. The controller side uses two valid/ready byte ports. It drains the outbound queue through one port and fills the inbound queue through the other.

Four event sources feed one maskable interrupt line: outbound empty, outbound not full, inbound not empty and inbound overflow. Each source latches a sticky request bit when its condition rises. The host acknowledges a request or the overflow flag by writing a 1 to it. Read-and-write-back of the same value therefore acknowledges every pending flag.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, `irq` is low, the interrupt word (index 0) reads 0x00000000 and the status word (index 2) reads 0x00000003.
- R2: A host write to index 1 queues `busWdata[15:8]` in the outbound queue. The controller receives the queued bytes in the order written. A write made while the outbound queue already holds DEPTH bytes is dropped.
- R3: A host read of index 1 returns the oldest inbound byte in bits 15:8, with every other bit zero, and removes that byte. When the inbound queue is empty, the read returns 0x00000000 and removes nothing.
- R4: Status bits come straight from queue occupancy. Bit 0 is outbound empty, bit 1 is outbound holding fewer than DEPTH bytes, and bit 2 is inbound holding at least one byte. DEPTH is 8 by default.
- R5: A controller push while the inbound queue is full drops the byte and sets status bit 3. Bit 3 stays set until the host writes index 2 with bit 3 at 1.
- R6: Interrupt word bits 3:0 latch when their condition goes from 0 to 1. The conditions are bit 0 outbound empty, bit 1 outbound not full, bit 2 inbound not empty and bit 3 the overflow flag. Each bit stays set after its condition falls.
- R7: Writing index 0 clears each request bit whose `busWdata[3:0]` bit is 1. Request bits written with 0 keep their value.
- R8: Writing index 0 loads mask bits 7:4 from `busWdata[7:4]`, and they read back in place. A mask bit at 1 enables the request bit four positions below it. `irq` is the OR of each request bit ANDed with its mask bit.
- R9: Indices 3 to 7 read as zero, and writes to them change nothing. Writing ones to status bits 2:0 has no effect.
- R10: `txValid` is high whenever the outbound queue is non-empty, and `txData` then shows the oldest byte. `rxReady` is low exactly when the inbound queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access strobe for this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Word index of the access |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Host read data, valid in the access cycle |
| irq | output | 1 | Interrupt to the host |
| txValid | output | 1 | Outbound byte available to the controller |
| txData | output | 8 | Oldest outbound byte |
| txReady | input | 1 | Controller takes the outbound byte |
| rxValid | input | 1 | Controller offers an inbound byte |
| rxData | input | 8 | Inbound byte |
| rxReady | output | 1 | Inbound queue can accept a byte |

## Verification
The bench uses the defaults DEPTH = 8 and ADDR_W = 3. At these values, nine pushes fill a queue and then overrun it. The bench therefore covers the dropped outbound write, the inbound overflow flag and the rise of the not-full request when the outbound queue drains from full. The small address space also lets the bench write and read back every reserved index.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int WORD_INTR = 0;
  localparam int WORD_DATA = 1;
  localparam int WORD_STAT = 2;
  localparam int NUM_SRC   = 4;

  typedef struct packed {
    logic       txPush;
    logic [7:0] txByte;
    logic       rxPop;
  } mboxStrobe_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: occupancy flags only move when the opposite operation happens
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    full && !pop |=> full);
  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    empty && !push |=> empty);

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  mboxStrobe_t strobe,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  output logic        rxReady,
  output logic [7:0]  rxHead,
  output logic        txEmpty,
  output logic        txFull,
  output logic        rxEmpty,
  output logic        rxDrop
);
  logic rxFull;

  mbox_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uTxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.txPush),
    .wrData (strobe.txByte),
    .pop    (txReady),
    .rdData (txData),
    .empty  (txEmpty),
    .full   (txFull)
  );

  mbox_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uRxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (rxValid),
    .wrData (rxData),
    .pop    (strobe.rxPop),
    .rdData (rxHead),
    .empty  (rxEmpty),
    .full   (rxFull)
  );

  assign txValid = !txEmpty;
  assign rxReady = !rxFull;
  assign rxDrop  = rxValid && rxFull;

  // R10: an offered outbound byte holds until the controller takes it
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output mboxStrobe_t       strobe,
  input  logic [7:0]        rxHead,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              rxDrop
);
  logic wrAccess, rdAccess, wrIntr, wrStat;
  logic ovfFlag;
  logic [NUM_SRC-1:0] condNow, condPrev, reqBits, maskBits, clrBits;
  logic [15:0] unusedWdata;

  assign unusedWdata = busWdata[31:16];
  assign wrAccess = busSel && busWr;
  assign rdAccess = busSel && !busWr;
  assign wrIntr   = wrAccess && (busAddr == ADDR_W'(WORD_INTR));
  assign wrStat   = wrAccess && (busAddr == ADDR_W'(WORD_STAT));

  assign strobe.txPush = wrAccess && (busAddr == ADDR_W'(WORD_DATA));
  assign strobe.txByte = busWdata[15:8];
  assign strobe.rxPop  = rdAccess && (busAddr == ADDR_W'(WORD_DATA));

  assign condNow = {ovfFlag, !rxEmpty, !txFull, txEmpty};
  assign clrBits = wrIntr ? busWdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      condPrev <= 4'b0011;
      reqBits  <= '0;
      maskBits <= '0;
    end else begin
      if (rxDrop)                   ovfFlag <= 1'b1;
      else if (wrStat && busWdata[3]) ovfFlag <= 1'b0;
      condPrev <= condNow;
      reqBits  <= (reqBits & ~clrBits) | (condNow & ~condPrev);
      if (wrIntr) maskBits <= busWdata[2*NUM_SRC-1:NUM_SRC];
    end
  end

  assign irq = |(reqBits & maskBits);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(WORD_INTR): busRdata = {24'd0, maskBits, reqBits};
      ADDR_W'(WORD_DATA): busRdata = rxEmpty ? 32'd0 : {16'd0, rxHead, 8'd0};
      ADDR_W'(WORD_STAT): busRdata = {28'd0, condNow};
      default:            busRdata = '0;
    endcase
  end

  // R5: overflow is set by a dropped push and held until acknowledged
  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |=> ovfFlag);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(wrStat && busWdata[3]) |=> ovfFlag);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gReqChk
    // R6: a rising condition latches its request bit
    assert_req_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(condNow[i]) |=> reqBits[i]);
    // R7: only a write of 1 removes a pending request
    assert_req_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      reqBits[i] && !(wrIntr && busWdata[i]) |=> reqBits[i]);
  end

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady
);
  mboxStrobe_t strobe;
  logic [7:0] rxHead;
  logic txEmpty, txFull, rxEmpty, rxDrop;

  mbox_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .strobe   (strobe),
    .rxHead   (rxHead),
    .txEmpty  (txEmpty),
    .txFull   (txFull),
    .rxEmpty  (rxEmpty),
    .rxDrop   (rxDrop)
  );

  mbox_datapath #(.DEPTH(DEPTH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .txValid (txValid),
    .txData  (txData),
    .txReady (txReady),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxReady (rxReady),
    .rxHead  (rxHead),
    .txEmpty (txEmpty),
    .txFull  (txFull),
    .rxEmpty (rxEmpty),
    .rxDrop  (rxDrop)
  );

endmodule

// File: tb/tb_mbox_bridge.sv
module tb_mbox_bridge;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, txValid, rxReady;
  logic [7:0] txData;
  logic txReady = 1'b0, rxValid = 1'b0;
  logic [7:0] rxData = '0;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  mbox_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [3:0] mReq, mMask, mPrev;
  logic mOvf;

  function automatic logic [3:0] modelCond();
    return {mOvf, rxQ.size() > 0, txQ.size() < DEPTH, txQ.size() == 0};
  endfunction

  function automatic logic [31:0] modelRead(input logic [ADDR_W-1:0] a);
    case (int'(a))
      0: return {24'd0, mMask, mReq};
      1: return (rxQ.size() == 0) ? 32'd0 : {16'd0, rxQ[0], 8'd0};
      2: return {28'd0, modelCond()};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mReq = '0; mMask = '0; mPrev = 4'b0011; mOvf = 1'b0;
    end else begin
      logic [3:0] cond;
      bit txFullNow, rxFullNow, txEmptyNow, rxEmptyNow;
      cond = modelCond();
      txFullNow = (txQ.size() == DEPTH); txEmptyNow = (txQ.size() == 0);
      rxFullNow = (rxQ.size() == DEPTH); rxEmptyNow = (rxQ.size() == 0);
      if (busSel && busWr && busAddr == 0) begin
        mReq = mReq & ~busWdata[3:0];
        mMask = busWdata[7:4];
      end
      mReq = mReq | (cond & ~mPrev);
      mPrev = cond;
      if (rxValid && rxFullNow) mOvf = 1'b1;
      else if (busSel && busWr && busAddr == 2 && busWdata[3]) mOvf = 1'b0;
      if (txReady && !txEmptyNow) void'(txQ.pop_front());
      if (busSel && busWr && busAddr == 1 && !txFullNow) txQ.push_back(busWdata[15:8]);
      if (busSel && !busWr && busAddr == 1 && !rxEmptyNow) void'(rxQ.pop_front());
      if (rxValid && !rxFullNow) rxQ.push_back(rxData);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of state-driven outputs (R8, R10)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R8 irq", {31'd0, irq}, {31'd0, |(mReq & mMask)});
      check("R10 txValid", {31'd0, txValid}, {31'd0, txQ.size() > 0});
      check("R10 rxReady", {31'd0, rxReady}, {31'd0, rxQ.size() < DEPTH});
      if (txQ.size() > 0) check("R10 txData", {24'd0, txData}, {24'd0, txQ[0]});
    end
  end

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input int a, input string req, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = ADDR_W'(a);
    #1;
    d = busRdata;
    check(req, d, modelRead(ADDR_W'(a)));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic mcuPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic mcuPop(input string req, input logic [7:0] exp);
    @(negedge clk);
    txReady = 1'b1;
    #1;
    check(req, {24'd0, txData}, {24'd0, exp});
    @(negedge clk);
    txReady = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    busRead(0, "R1 intr reset", d);  check("R1 intr value", d, 32'h0);
    busRead(2, "R1 stat reset", d);  check("R1 stat value", d, 32'h3);
    check("R1 irq", {31'd0, irq}, 32'd0);

    busWrite(1, {16'hDEAD, 8'hA1, 8'h5A});
    busWrite(1, {16'hBEEF, 8'hB2, 8'hFF});
    busWrite(1, {16'h0000, 8'hC3, 8'h00});
    busRead(2, "R4 stat partial", d); check("R4 stat three bytes", d, 32'h2);
    mcuPop("R2 order", 8'hA1);
    mcuPop("R2 order", 8'hB2);
    mcuPop("R2 order", 8'hC3);
    repeat (2) @(negedge clk);
    busRead(0, "R6 intr", d); check("R6 empty req", {31'd0, d[0]}, 32'd1);

    for (int i = 0; i < DEPTH + 1; i++) busWrite(1, {16'd0, 8'(8'h10 + i), 8'd0});
    busRead(2, "R4 stat full", d); check("R4 stat full value", d, 32'h0);
    for (int i = 0; i < DEPTH; i++) mcuPop("R2 full order", 8'(8'h10 + i));
    #1 check("R2 ninth dropped", {31'd0, txValid}, 32'd0);
    repeat (2) @(negedge clk);
    busRead(0, "R6 intr notfull", d); check("R6 notfull req", {30'd0, d[1:0]}, 32'h3);
    busWrite(0, 32'h1);
    busRead(0, "R7 intr clear", d); check("R7 partial clear", {30'd0, d[1:0]}, 32'h2);

    mcuPush(8'h5C); mcuPush(8'h6D);
    busRead(1, "R3 pop", d); check("R3 byte 5C", d, 32'h5C00);
    busRead(1, "R3 pop", d); check("R3 byte 6D", d, 32'h6D00);
    busRead(1, "R3 empty", d); check("R3 empty read", d, 32'h0);

    for (int i = 0; i < DEPTH + 1; i++) mcuPush(8'(8'h80 + i));
    #1 check("R10 rxReady full", {31'd0, rxReady}, 32'd0);
    busRead(2, "R5 stat ovf", d); check("R5 ovf set", d, 32'hF);
    busRead(1, "R3 pop", d); check("R3 byte 80", d, 32'h8000);
    busWrite(2, 32'h7);
    busRead(2, "R9 stat ignore", d); check("R9 stat bits ignored", d, 32'hF);
    busWrite(2, 32'h8);
    busRead(2, "R5 stat clear", d); check("R5 ovf cleared", d, 32'h7);
    for (int i = 1; i < DEPTH; i++) begin
      busRead(1, "R3 drain", d);
      check("R3 drain byte", d, {16'd0, 8'(8'h80 + i), 8'd0});
    end

    busWrite(0, 32'h4F);
    #1 check("R8 irq masked", {31'd0, irq}, 32'd0);
    mcuPush(8'h33);
    repeat (3) @(negedge clk);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    busWrite(0, 32'h00);
    #1 check("R8 irq unmasked", {31'd0, irq}, 32'd0);
    busRead(0, "R8 intr", d); check("R8 mask readback", d, 32'h04);

    for (int a = 3; a < 8; a++) begin
      busWrite(a, 32'hFFFF_FFFF);
      busRead(a, "R9 reserved", d); check("R9 reserved zero", d, 32'h0);
    end
    busRead(0, "R9 intr unchanged", d); check("R9 intr value", d, 32'h04);
    busRead(1, "R3 pop", d); check("R3 byte 33", d, 32'h3300);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule